// File: doc/BRIEF.md
# Cache Tag Maintenance Command Engine

This block holds the tag and valid state of a 256 KB, 4-way set-associative cache with 32-byte lines, which gives 2048 sets. Next to that array sits a small command engine. Software loads a target address into an address register and then writes a 2-bit command code. The engine can sweep the whole array clear, drop the one line that matches the address, or clear either of two latched parity-error flags. While a command runs, the engine shows busy. When the command finishes, it raises a completion flag that software polls before it issues the next command.

A probe port gives the state of the array as hit or miss for any byte address. The same port can install a tag into a chosen way, which stands in for a line fill so that lines exist to be maintained. Data storage, refill traffic and the bus protocol sit outside this block. After reset the engine runs a full sweep by itself, so the valid state is known before software first sees the completion flag.

Top module: `cache_tag_maint`

## Requirements
- R1: A byte address splits into line offset bits [4:0], set index bits [15:5] and tag bits [31:16]. `probeHit` is 1 only when some way of the indexed set holds a valid line whose stored tag equals the address tag, whatever the offset bits are.
- R2: A write through `addrWe` while idle stores `addrIn` with bits [3:0] forced to zero, and `cmdAddrQ` shows the stored value from the next cycle on.
- R3: Command codes are 0 = sweep all, 1 = invalidate one line, 2 = clear data-parity flag, 3 = clear tag-parity flag. A `cmdWe` pulse while idle makes `cmdDone` 0 and `cmdBusy` 1 after that clock edge. `cmdDone` then stays 0 until the command completes, and stays 1 while no command runs.
- R4: A sweep clears one set per cycle, starting at set 0. `cmdDone` rises at the 2048th clock edge after the command edge, and no line is valid afterwards.
- R5: An invalidate completes at the first clock edge after the command edge. It drops only the way of the indexed set whose tag matches `cmdAddrQ`, and leaves every other way and every other set as it was.
- R6: An invalidate of an address that is not present completes with the same timing and changes no line.
- R7: A `dataParSet` or `tagParSet` pulse sets its flag. A flag is cleared only by its own command, which completes one cycle after the command edge. If a set pulse arrives in the same cycle as the clear, the set wins.
- R8: While `cmdBusy` is 1, command writes, address writes and probe installs are ignored.
- R9: During reset `cmdBusy` is 1, `cmdDone` is 0 and both parity flags are 0. After reset is released the array is swept, and `cmdDone` rises at the 2048th clock edge.
- R10: A `probeFill` pulse while idle writes the tag of `probeAddr` into way `probeWay` of the indexed set and marks that line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrWe | input | 1 | Address register write strobe |
| addrIn | input | 32 | Address register write data |
| cmdWe | input | 1 | Command register write strobe |
| cmdCode | input | 2 | Command code (0 sweep, 1 invalidate, 2 clear data parity, 3 clear tag parity) |
| dataParSet | input | 1 | Data-parity error event |
| tagParSet | input | 1 | Tag-parity error event |
| probeAddr | input | 32 | Byte address for lookup or install |
| probeFill | input | 1 | Install the tag of probeAddr |
| probeWay | input | 2 | Way selected for an install |
| cmdAddrQ | output | 32 | Address register read-back |
| cmdDone | output | 1 | Command-complete status |
| cmdBusy | output | 1 | Command in progress |
| dataParFlag | output | 1 | Latched data-parity error |
| tagParFlag | output | 1 | Latched tag-parity error |
| probeHit | output | 1 | Lookup result for probeAddr |

## Verification
The uniqueness assertion assumes that software never installs the same tag into two ways of one set, because the array does not prevent duplicates. The other properties assume that commands are issued only after the sweep that follows reset has finished. The stimulus installs each tag into exactly one way. It re-installs a line only after that line has been invalidated, and it always waits for `cmdDone` before the next command, except in the test that writes on purpose while the engine is busy.

// File: rtl/cache_tag_maint_pkg.sv
package cache_tag_maint_pkg;

  typedef enum logic [1:0] {
    OP_SWEEP    = 2'd0,
    OP_INVAL    = 2'd1,
    OP_CLR_DPAR = 2'd2,
    OP_CLR_TPAR = 2'd3
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_INVAL,
    ST_CLR_DPAR,
    ST_CLR_TPAR
  } seqState_e;

  // strobes from the sequencer to the tag array
  typedef struct packed {
    logic clrSet;   // clear all ways of sweepIdx
    logic invLine;  // drop the matching way of the command set
    logic fillOk;   // engine idle, installs allowed
  } dpStrobe_t;

endpackage

// File: rtl/ctm_ctrl.sv
module ctm_ctrl
  import cache_tag_maint_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 2048,
  parameter int ZERO_BITS = 4,
  localparam int IDX_W    = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmdWe,
  input  logic [1:0]        cmdCode,
  input  logic              dataParSet,
  input  logic              tagParSet,
  output dpStrobe_t         strb,
  output logic [IDX_W-1:0]  sweepIdx,
  output logic [ADDR_W-1:0] cmdAddrQ,
  output logic              cmdDone,
  output logic              cmdBusy,
  output logic              dataParFlag,
  output logic              tagParFlag
);

  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

  seqState_e state;
  logic      startCmd;

  assign cmdBusy  = (state != ST_IDLE);
  assign startCmd = cmdWe && !cmdBusy;

  always_comb begin
    strb.clrSet  = (state == ST_SWEEP);
    strb.invLine = (state == ST_INVAL);
    strb.fillOk  = !cmdBusy;
  end

  // address register, low bits forced to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAddrQ <= '0;
    end else if (addrWe && !cmdBusy) begin
      cmdAddrQ <= {addrIn[ADDR_W-1:ZERO_BITS], ZERO_BITS'(0)};
    end
  end

  // sequencer; reset starts a full sweep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SWEEP;
      sweepIdx <= '0;
      cmdDone  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startCmd) begin
            cmdDone <= 1'b0;
            unique case (opcode_e'(cmdCode))
              OP_SWEEP: begin
                state    <= ST_SWEEP;
                sweepIdx <= '0;
              end
              OP_INVAL:    state <= ST_INVAL;
              OP_CLR_DPAR: state <= ST_CLR_DPAR;
              OP_CLR_TPAR: state <= ST_CLR_TPAR;
            endcase
          end
        end
        ST_SWEEP: begin
          if (sweepIdx == LAST_SET) begin
            state   <= ST_IDLE;
            cmdDone <= 1'b1;
          end else begin
            sweepIdx <= sweepIdx + IDX_W'(1);
          end
        end
        default: begin
          state   <= ST_IDLE;
          cmdDone <= 1'b1;
        end
      endcase
    end
  end

  // latched parity flags; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataParFlag <= 1'b0;
      tagParFlag  <= 1'b0;
    end else begin
      if (dataParSet)                dataParFlag <= 1'b1;
      else if (state == ST_CLR_DPAR) dataParFlag <= 1'b0;
      if (tagParSet)                 tagParFlag  <= 1'b1;
      else if (state == ST_CLR_TPAR) tagParFlag  <= 1'b0;
    end
  end

  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (!cmdDone && cmdBusy)); // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !cmdWe) |=> cmdDone); // R3
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && sweepIdx != LAST_SET) |=>
      (state == ST_SWEEP && sweepIdx == $past(sweepIdx) + IDX_W'(1))); // R4
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && sweepIdx == LAST_SET) |=> (cmdDone && !cmdBusy)); // R4
  AST_SHORT_CMD_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_INVAL, ST_CLR_DPAR, ST_CLR_TPAR}) |=> cmdDone); // R5
  AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |=> $stable(cmdAddrQ)); // R8
  AST_DPAR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    dataParSet |=> dataParFlag); // R7
  AST_TPAR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    tagParSet |=> tagParFlag); // R7

endmodule

// File: rtl/ctm_tagarray.sv
module ctm_tagarray
  import cache_tag_maint_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 2048,
  parameter int OFF_W  = 5,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  sweepIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic              probeFill,
  input  logic [WAY_W-1:0]  probeWay,
  output logic              probeHit
);

  logic [IDX_W-1:0] cmdIdx, prbIdx;
  logic [TAG_W-1:0] cmdTag, prbTag;
  logic [WAYS-1:0]  cmdMatch, prbMatch;

  assign cmdIdx = cmdAddr[OFF_W +: IDX_W];
  assign cmdTag = cmdAddr[ADDR_W-1 -: TAG_W];
  assign prbIdx = probeAddr[OFF_W +: IDX_W];
  assign prbTag = probeAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tagMem [SETS];
    logic             vldMem [SETS];

    assign cmdMatch[w] = vldMem[cmdIdx] && (tagMem[cmdIdx] == cmdTag);
    assign prbMatch[w] = vldMem[prbIdx] && (tagMem[prbIdx] == prbTag);

    always_ff @(posedge clk) begin
      if (strb.clrSet) begin
        vldMem[sweepIdx] <= 1'b0;
      end else if (strb.invLine && cmdMatch[w]) begin
        vldMem[cmdIdx] <= 1'b0;
      end else if (strb.fillOk && probeFill && probeWay == WAY_W'(w)) begin
        vldMem[prbIdx] <= 1'b1;
        tagMem[prbIdx] <= prbTag;
      end
    end
  end

  assign probeHit = |prbMatch;

  AST_INV_LEAVES_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.invLine |=> (cmdMatch == '0)); // R5
  AST_WAY_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillOk |-> $onehot0(prbMatch)); // R1
  AST_SWEPT_SET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrSet && prbIdx == sweepIdx) |=>
      (!probeHit || $past(prbIdx) != prbIdx)); // R4

endmodule

// File: rtl/cache_tag_maint.sv
module cache_tag_maint
  import cache_tag_maint_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 262144,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 32,
  parameter int ZERO_BITS   = 4,
  localparam int SETS       = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmdWe,
  input  logic [1:0]        cmdCode,
  input  logic              dataParSet,
  input  logic              tagParSet,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic              probeFill,
  input  logic [WAY_W-1:0]  probeWay,
  output logic [ADDR_W-1:0] cmdAddrQ,
  output logic              cmdDone,
  output logic              cmdBusy,
  output logic              dataParFlag,
  output logic              tagParFlag,
  output logic              probeHit
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] sweepIdx;

  ctm_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .ZERO_BITS(ZERO_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .addrWe(addrWe), .addrIn(addrIn),
    .cmdWe(cmdWe), .cmdCode(cmdCode),
    .dataParSet(dataParSet), .tagParSet(tagParSet),
    .strb(strb), .sweepIdx(sweepIdx), .cmdAddrQ(cmdAddrQ),
    .cmdDone(cmdDone), .cmdBusy(cmdBusy),
    .dataParFlag(dataParFlag), .tagParFlag(tagParFlag)
  );

  ctm_tagarray #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .OFF_W(OFF_W)
  ) tags_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .sweepIdx(sweepIdx), .cmdAddr(cmdAddrQ),
    .probeAddr(probeAddr), .probeFill(probeFill), .probeWay(probeWay),
    .probeHit(probeHit)
  );

endmodule

// File: tb/cache_tag_maint_tb_top.sv
module cache_tag_maint_tb_top;

  localparam int SETS = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrWe = 1'b0;
  logic [31:0] addrIn = '0;
  logic        cmdWe = 1'b0;
  logic [1:0]  cmdCode = '0;
  logic        dataParSet = 1'b0;
  logic        tagParSet = 1'b0;
  logic [31:0] probeAddr = '0;
  logic        probeFill = 1'b0;
  logic [1:0]  probeWay = '0;
  logic [31:0] cmdAddrQ;
  logic        cmdDone, cmdBusy, dataParFlag, tagParFlag, probeHit;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  cache_tag_maint dut_i (
    .clk(clk), .rstN(rstN), .addrWe(addrWe), .addrIn(addrIn),
    .cmdWe(cmdWe), .cmdCode(cmdCode), .dataParSet(dataParSet),
    .tagParSet(tagParSet), .probeAddr(probeAddr), .probeFill(probeFill),
    .probeWay(probeWay), .cmdAddrQ(cmdAddrQ), .cmdDone(cmdDone),
    .cmdBusy(cmdBusy), .dataParFlag(dataParFlag), .tagParFlag(tagParFlag),
    .probeHit(probeHit)
  );

  // op: 0 install(arg=way) 1 probe(exp) 2 invalidate 3 sweep
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [1:0]  arg;
    logic        exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0001_2340, 2'd0, 1'b0},
    '{2'd0, 32'h0002_2340, 2'd1, 1'b0},
    '{2'd0, 32'h0003_2360, 2'd2, 1'b0},
    '{2'd0, 32'h0005_2340, 2'd3, 1'b0},
    '{2'd1, 32'h0001_2340, 2'd0, 1'b1},
    '{2'd1, 32'h0002_2340, 2'd0, 1'b1},
    '{2'd1, 32'h0003_2360, 2'd0, 1'b1},
    '{2'd1, 32'h0001_235F, 2'd0, 1'b1},
    '{2'd1, 32'h0004_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0001_2360, 2'd0, 1'b0},
    '{2'd2, 32'h0004_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0001_2340, 2'd0, 1'b1},
    '{2'd1, 32'h0002_2340, 2'd0, 1'b1},
    '{2'd1, 32'h0005_2340, 2'd0, 1'b1},
    '{2'd2, 32'h0001_235F, 2'd0, 1'b0},
    '{2'd1, 32'h0001_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0002_2340, 2'd0, 1'b1},
    '{2'd1, 32'h0003_2360, 2'd0, 1'b1},
    '{2'd2, 32'h0002_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0002_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0005_2340, 2'd0, 1'b1},
    '{2'd0, 32'h0001_2340, 2'd0, 1'b0},
    '{2'd1, 32'h0001_2344, 2'd0, 1'b1},
    '{2'd3, 32'h0000_0000, 2'd0, 1'b0},
    '{2'd1, 32'h0003_2360, 2'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic install(input logic [31:0] a, input logic [1:0] w);
    @(negedge clk); probeAddr = a; probeWay = w; probeFill = 1'b1;
    @(negedge clk); probeFill = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic e);
    @(negedge clk); probeAddr = a;
    #1 check(req, {31'd0, probeHit}, {31'd0, e});
  endtask

  task automatic setAddr(input logic [31:0] a);
    @(negedge clk); addrWe = 1'b1; addrIn = a;
    @(negedge clk); addrWe = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmdWe = 1'b1; cmdCode = c;
    @(negedge clk); cmdWe = 1'b0;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!cmdDone && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 busy in reset", {31'd0, cmdBusy}, 32'd1);
    check("R9 done in reset", {31'd0, cmdDone}, 32'd0);
    check("R9 parity flags in reset", {30'd0, dataParFlag, tagParFlag}, 32'd0);
    rstN = 1'b1;
    waitDone(n);
    check("R9 post-reset sweep length", n, SETS);
    probe("R9 array empty", 32'h0000_0000, 1'b0);
    probe("R9 array empty", 32'hFFFF_FFE0, 1'b0);

    // R2 address read-back
    setAddr(32'hDEAD_BEEF);
    check("R2 low bits zero", cmdAddrQ, 32'hDEAD_BEE0);

    // vector walk: R1 R5 R6 R10 R4
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: install(VECS[i].addr, VECS[i].arg);
        2'd1: probe("R1 R10 probe", VECS[i].addr, VECS[i].exp);
        2'd2: begin
          setAddr(VECS[i].addr);
          issue(2'd1);
          check("R3 done drops", {31'd0, cmdDone}, 32'd0);
          waitDone(n);
          check("R5 R6 invalidate latency", n, 1);
        end
        default: begin
          setAddr(32'h0);
          issue(2'd0);
          check("R3 busy after start", {31'd0, cmdBusy}, 32'd1);
          waitDone(n);
          check("R4 sweep length", n, SETS);
        end
      endcase
    end

    // R8 writes while busy are ignored
    setAddr(32'h0);
    issue(2'd0);
    repeat (100) @(negedge clk);
    setAddr(32'h1234_5670);
    check("R8 addr write ignored", cmdAddrQ, 32'h0);
    issue(2'd1);
    install(32'h0009_0000, 2'd0);
    waitDone(n);
    check("R8 sweep still completes", {31'd0, cmdDone}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 no queued command", {31'd0, cmdDone}, 32'd1);
    end
    check("R8 addr after busy", cmdAddrQ, 32'h0);
    probe("R8 install ignored", 32'h0009_0000, 1'b0);

    // R7 parity flags
    @(negedge clk); dataParSet = 1'b1;
    @(negedge clk); dataParSet = 1'b0;
    check("R7 data flag set", {30'd0, dataParFlag, tagParFlag}, 32'd2);
    @(negedge clk); tagParSet = 1'b1;
    @(negedge clk); tagParSet = 1'b0;
    check("R7 both flags set", {30'd0, dataParFlag, tagParFlag}, 32'd3);
    issue(2'd2);
    waitDone(n);
    check("R7 clear latency", n, 1);
    check("R7 only data cleared", {30'd0, dataParFlag, tagParFlag}, 32'd1);
    issue(2'd3);
    waitDone(n);
    check("R7 tag cleared", {30'd0, dataParFlag, tagParFlag}, 32'd0);
    // set in the clearing cycle wins
    @(negedge clk); dataParSet = 1'b1;
    @(negedge clk); dataParSet = 1'b0;
    @(negedge clk); cmdWe = 1'b1; cmdCode = 2'd2;
    @(negedge clk); cmdWe = 1'b0; dataParSet = 1'b1;
    @(negedge clk); dataParSet = 1'b0;
    check("R7 done after clear", {31'd0, cmdDone}, 32'd1);
    check("R7 set wins over clear", {31'd0, dataParFlag}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule